// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This block services an acknowledge read from a virtual CPU interface for either interrupt group. It is given the best pending list-register entry (already chosen elsewhere) together with a valid flag, a grant from the preemption checker and the binary point that applies to the requested group. From these it decides in the strobe cycle which ID the read returns and how the list-register entry must be rewritten. For each group it also keeps an array of active-priority bits, where it records the group priority of every interrupt it activates.

An ordinary interrupt goes from pending to active, and one active-priority bit is set in the array of its group. The bit is chosen by the interrupt's priority with the subpriority bits masked off. An ID in the reserved range from 1020 upward is still handed back to the reader, but its entry only loses the pending bit and never becomes active. Every other case answers with the spurious ID and changes nothing. Selecting the pending entry, and dropping priority on end of interrupt, belong to neighbouring blocks.

Top module: `vack_unit`

## Requirements
- R1: With `cand_valid` low, a strobed read returns 1023 on `ack_id`, keeps `lr_we` low and leaves both active-priority arrays unchanged.
- R2: When `cand_grp` differs from `rd_grp` (0 = group 0, 1 = group 1), a strobed read returns 1023 and changes no state.
- R3: When `preempt_ok` is low, a strobed read returns 1023 and changes no state.
- R4: A granted read (strobe, valid candidate, matching group, preemption allowed) of an ID below 1020 returns the ID. In the same cycle it raises `lr_we` with `lr_widx` = `cand_idx` and `lr_wstate` = 2'b10 (bit 1 active, bit 0 pending).
- R5: For an ordinary granted read, the active-priority bit index is (cand_prio & mask) >> (8 − PRIO_BITS), where mask = 8'hFF << (vbpr + 1), and vbpr = 7 gives a zero mask.
- R6: The bit at that index (word index/32, bit index%32, flat bit index of the port) is set in `apr_g0` or `apr_g1` according to `rd_grp` at the clock edge that ends the strobe cycle. No other bit in either array changes.
- R7: A granted read of an ID of 1020 or above, up to the 24-bit maximum, returns that ID and writes `lr_wstate` = {cand_state[1], 1'b0}. Both arrays stay unchanged.
- R8: With `rd_stb` low, `ack_id` is 1023, `lr_we` is low and the arrays hold, whatever the candidate inputs are.
- R9: A synchronous reset clears both active-priority arrays. No bit is ever cleared outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle acknowledge read strobe |
| rd_grp | input | 1 | Group the read asks for |
| cand_valid | input | 1 | A pending candidate exists |
| cand_idx | input | LR_IDX_W | List-register index of the candidate |
| cand_id | input | 24 | Virtual interrupt ID of the candidate |
| cand_prio | input | 8 | Priority of the candidate |
| cand_grp | input | 1 | Group of the candidate |
| cand_state | input | 2 | Current state of the candidate entry (bit 1 active, bit 0 pending) |
| preempt_ok | input | 1 | Preemption checker allows signalling |
| vbpr | input | 3 | Binary point for the requested group |
| ack_id | output | 24 | ID returned by the read |
| lr_we | output | 1 | List-register state write enable |
| lr_widx | output | LR_IDX_W | List-register index to write |
| lr_wstate | output | 2 | New state for that entry |
| apr_g0 | output | APR_W | Group 0 active-priority array, words concatenated |
| apr_g1 | output | APR_W | Group 1 active-priority array, words concatenated |

## Verification
On every cycle the assertions check the following. An idle or refused read always returns the spurious ID and leaves the arrays and the list registers alone. The write-back state is right for both ordinary and reserved IDs. No single read changes more than one active-priority bit. Bits only disappear through reset. The exact bit index, however, depends on how priority, binary point and group combine, and only the bench's reference model shows it. The same goes for words past the first, such as bit 127 of group 1, and for the masking when the binary point is 7, so those cases come from directed and random scenarios.

// File: rtl/vack_pkg.sv
package vack_pkg;

    localparam int ID_W = 24;
    localparam logic [ID_W-1:0] SPURIOUS_ID   = 24'd1023;
    localparam logic [ID_W-1:0] FIRST_SPECIAL = 24'd1020;

    typedef enum logic {
        GRP0 = 1'b0,
        GRP1 = 1'b1
    } grp_e;

    typedef enum logic [1:0] {
        ACK_NONE,
        ACK_NORMAL,
        ACK_SPECIAL
    } ack_kind_e;

    typedef struct packed {
        logic active;
        logic pending;
    } lr_state_t;

    // Mask keeping only group-priority bits for a given binary point.
    function automatic logic [7:0] gprio_mask(input logic [2:0] bpr);
        logic [3:0] sh;
        sh = {1'b0, bpr} + 4'd1;
        return 8'hFF << sh;
    endfunction

endpackage

// File: rtl/vack_gate.sv
module vack_gate
    import vack_pkg::*;
(
    input  logic            rd_stb,
    input  grp_e            rd_grp,
    input  logic            cand_valid,
    input  grp_e            cand_grp,
    input  logic            preempt_ok,
    input  logic [ID_W-1:0] cand_id,
    output ack_kind_e       kind,
    output logic [ID_W-1:0] ack_id
);

    logic eligible;

    assign eligible = rd_stb && cand_valid && (cand_grp == rd_grp) && preempt_ok;

    always_comb begin
        kind   = ACK_NONE;
        ack_id = SPURIOUS_ID;
        if (eligible) begin
            ack_id = cand_id;
            kind   = (cand_id < FIRST_SPECIAL) ? ACK_NORMAL : ACK_SPECIAL;
        end
    end

endmodule

// File: rtl/vack_aprsel.sv
module vack_aprsel
    import vack_pkg::*;
#(
    parameter int PRIO_BITS = 7,
    parameter int APR_W     = 128
) (
    input  logic [7:0]       prio,
    input  logic [2:0]       bpr,
    output logic [APR_W-1:0] onehot
);

    localparam int SHIFT = 8 - PRIO_BITS;

    logic [7:0]           masked;
    logic [PRIO_BITS-1:0] bit_idx;

    assign masked  = prio & gprio_mask(bpr);
    assign bit_idx = masked[7:SHIFT];

    always_comb begin
        onehot          = '0;
        onehot[bit_idx] = 1'b1;
    end

endmodule

// File: rtl/vack_aprbank.sv
module vack_aprbank
    import vack_pkg::*;
#(
    parameter int APR_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  grp_e             set_grp,
    input  logic [APR_W-1:0] set_vec,
    output logic [APR_W-1:0] apr_g0,
    output logic [APR_W-1:0] apr_g1
);

    logic [1:0][APR_W-1:0] apr_q;

    for (genvar g = 0; g < 2; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) begin
                apr_q[g] <= '0;
            end else if (set_en && (set_grp == grp_e'(g))) begin
                apr_q[g] <= apr_q[g] | set_vec;
            end
        end
    end

    assign apr_g0 = apr_q[0];
    assign apr_g1 = apr_q[1];

endmodule

// File: rtl/vack_unit.sv
module vack_unit
    import vack_pkg::*;
#(
    parameter int NUM_LR    = 8,
    parameter int PRIO_BITS = 7,
    localparam int LR_IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
    localparam int APR_WORDS = 1 << (PRIO_BITS - 5),
    localparam int APR_W     = APR_WORDS * 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_stb,
    input  logic                rd_grp,
    input  logic                cand_valid,
    input  logic [LR_IDX_W-1:0] cand_idx,
    input  logic [23:0]         cand_id,
    input  logic [7:0]          cand_prio,
    input  logic                cand_grp,
    input  logic [1:0]          cand_state,
    input  logic                preempt_ok,
    input  logic [2:0]          vbpr,
    output logic [23:0]         ack_id,
    output logic                lr_we,
    output logic [LR_IDX_W-1:0] lr_widx,
    output logic [1:0]          lr_wstate,
    output logic [APR_W-1:0]    apr_g0,
    output logic [APR_W-1:0]    apr_g1
);

    ack_kind_e        kind;
    logic [APR_W-1:0] set_vec;
    lr_state_t        cur_st;
    lr_state_t        nxt_st;

    vack_gate u_gate (
        .rd_stb     (rd_stb),
        .rd_grp     (grp_e'(rd_grp)),
        .cand_valid (cand_valid),
        .cand_grp   (grp_e'(cand_grp)),
        .preempt_ok (preempt_ok),
        .cand_id    (cand_id),
        .kind       (kind),
        .ack_id     (ack_id)
    );

    vack_aprsel #(
        .PRIO_BITS (PRIO_BITS),
        .APR_W     (APR_W)
    ) u_sel (
        .prio   (cand_prio),
        .bpr    (vbpr),
        .onehot (set_vec)
    );

    vack_aprbank #(
        .APR_W (APR_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_en  (kind == ACK_NORMAL),
        .set_grp (grp_e'(rd_grp)),
        .set_vec (set_vec),
        .apr_g0  (apr_g0),
        .apr_g1  (apr_g1)
    );

    assign cur_st = lr_state_t'(cand_state);

    always_comb begin
        nxt_st = cur_st;
        unique case (kind)
            ACK_NORMAL: begin
                nxt_st.pending = 1'b0;
                nxt_st.active  = 1'b1;
            end
            ACK_SPECIAL: nxt_st.pending = 1'b0;
            default:     nxt_st = cur_st;
        endcase
    end

    assign lr_we     = (kind != ACK_NONE);
    assign lr_widx   = cand_idx;
    assign lr_wstate = nxt_st;

endmodule

// File: rtl/vack_unit_chk.sv
module vack_unit_chk #(
    parameter int NUM_LR    = 8,
    parameter int PRIO_BITS = 7,
    localparam int LR_IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
    localparam int APR_W     = (1 << (PRIO_BITS - 5)) * 32
) (
    input logic                clk,
    input logic                rst,
    input logic                rd_stb,
    input logic                rd_grp,
    input logic                cand_valid,
    input logic [LR_IDX_W-1:0] cand_idx,
    input logic [23:0]         cand_id,
    input logic [7:0]          cand_prio,
    input logic                cand_grp,
    input logic [1:0]          cand_state,
    input logic                preempt_ok,
    input logic [2:0]          vbpr,
    input logic [23:0]         ack_id,
    input logic                lr_we,
    input logic [LR_IDX_W-1:0] lr_widx,
    input logic [1:0]          lr_wstate,
    input logic [APR_W-1:0]    apr_g0,
    input logic [APR_W-1:0]    apr_g1
);

    logic granted;
    assign granted = rd_stb && cand_valid && (cand_grp == rd_grp) && preempt_ok;

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |-> (!lr_we && ack_id == 24'd1023));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ($stable(apr_g0) && $stable(apr_g1)));

    // R1 R2 R3
    refused_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !granted) |-> (!lr_we && ack_id == 24'd1023));

    // R1 R2 R3
    refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !granted) |=> ($stable(apr_g0) && $stable(apr_g1)));

    // R4
    normal_write_chk: assert property (@(posedge clk) disable iff (rst)
        (granted && cand_id < 24'd1020) |->
            (lr_we && lr_wstate == 2'b10 && lr_widx == cand_idx && ack_id == cand_id));

    // R7
    special_write_chk: assert property (@(posedge clk) disable iff (rst)
        (granted && cand_id >= 24'd1020) |->
            (lr_we && lr_wstate == {cand_state[1], 1'b0} && ack_id == cand_id));

    // R7
    special_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (granted && cand_id >= 24'd1020) |=> ($stable(apr_g0) && $stable(apr_g1)));

    // R6
    single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> ($countones(apr_g0 ^ $past(apr_g0)) +
                    $countones(apr_g1 ^ $past(apr_g1)) <= 1));

    // R9
    no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((apr_g0 & $past(apr_g0)) == $past(apr_g0)) &&
                  ((apr_g1 & $past(apr_g1)) == $past(apr_g1))));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (apr_g0 == '0 && apr_g1 == '0));

endmodule

bind vack_unit vack_unit_chk #(
    .NUM_LR    (NUM_LR),
    .PRIO_BITS (PRIO_BITS)
) i_chk (.*);

// File: tb/test_vack_unit.sv
module test_vack_unit;

    localparam int NUM_LR    = 8;
    localparam int PRIO_BITS = 7;
    localparam int LR_IDX_W  = $clog2(NUM_LR);
    localparam int APR_W     = (1 << (PRIO_BITS - 5)) * 32;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                rd_stb = 1'b0;
    logic                rd_grp = 1'b0;
    logic                cand_valid = 1'b0;
    logic [LR_IDX_W-1:0] cand_idx = '0;
    logic [23:0]         cand_id = '0;
    logic [7:0]          cand_prio = '0;
    logic                cand_grp = 1'b0;
    logic [1:0]          cand_state = '0;
    logic                preempt_ok = 1'b0;
    logic [2:0]          vbpr = '0;
    logic [23:0]         ack_id;
    logic                lr_we;
    logic [LR_IDX_W-1:0] lr_widx;
    logic [1:0]          lr_wstate;
    logic [APR_W-1:0]    apr_g0;
    logic [APR_W-1:0]    apr_g1;

    logic [APR_W-1:0]    mdl_g0;
    logic [APR_W-1:0]    mdl_g1;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    vack_unit #(
        .NUM_LR    (NUM_LR),
        .PRIO_BITS (PRIO_BITS)
    ) i_vack_unit (
        .clk        (clk),
        .rst        (rst),
        .rd_stb     (rd_stb),
        .rd_grp     (rd_grp),
        .cand_valid (cand_valid),
        .cand_idx   (cand_idx),
        .cand_id    (cand_id),
        .cand_prio  (cand_prio),
        .cand_grp   (cand_grp),
        .cand_state (cand_state),
        .preempt_ok (preempt_ok),
        .vbpr       (vbpr),
        .ack_id     (ack_id),
        .lr_we      (lr_we),
        .lr_widx    (lr_widx),
        .lr_wstate  (lr_wstate),
        .apr_g0     (apr_g0),
        .apr_g1     (apr_g1)
    );

    function automatic int ref_index(input logic [7:0] prio, input logic [2:0] bpr);
        int m;
        m = (bpr == 3'd7) ? 0 : ((255 << (int'(bpr) + 1)) & 255);
        return (int'(prio) & m) >> (8 - PRIO_BITS);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [APR_W-1:0] act, input logic [APR_W-1:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one read just after a falling edge, check outputs, then check arrays one edge later.
    task automatic apply(input bit stb, input bit grp, input bit valid,
                         input logic [LR_IDX_W-1:0] idx, input logic [23:0] id,
                         input logic [7:0] prio, input bit cgrp, input logic [1:0] st,
                         input bit pok, input logic [2:0] bpr, input string req);
        bit          grant;
        bit          special;
        logic [23:0] e_id;
        logic [1:0]  e_st;
        int          bidx;
        rd_stb = stb; rd_grp = grp; cand_valid = valid; cand_idx = idx;
        cand_id = id; cand_prio = prio; cand_grp = cgrp; cand_state = st;
        preempt_ok = pok; vbpr = bpr;
        #2;
        grant   = stb && valid && (cgrp == grp) && pok;
        special = (id >= 24'd1020);
        e_id    = grant ? id : 24'd1023;
        e_st    = special ? {st[1], 1'b0} : 2'b10;
        check(ack_id == e_id, req, "ack_id", APR_W'(ack_id), APR_W'(e_id));
        check(lr_we == grant, req, "lr_we", APR_W'(lr_we), APR_W'(grant));
        if (grant) begin
            check(lr_wstate == e_st, req, "lr_wstate", APR_W'(lr_wstate), APR_W'(e_st));
            check(lr_widx == idx, req, "lr_widx", APR_W'(lr_widx), APR_W'(idx));
            if (!special) begin
                bidx = ref_index(prio, bpr);
                if (grp) mdl_g1[bidx] = 1'b1;
                else     mdl_g0[bidx] = 1'b1;
            end
        end
        @(negedge clk);
        check(apr_g0 == mdl_g0, req, "apr_g0", apr_g0, mdl_g0);
        check(apr_g1 == mdl_g1, req, "apr_g1", apr_g1, mdl_g1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [23:0] rid;
        mdl_g0 = '0;
        mdl_g1 = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: arrays clear after reset
        check(apr_g0 == '0 && apr_g1 == '0, "R9", "reset arrays", apr_g0 | apr_g1, '0);

        // R1: no candidate
        apply(1, 0, 0, 3'd1, 24'd5, 8'h40, 0, 2'b01, 1, 3'd2, "R1");
        // R2: group mismatch
        apply(1, 1, 1, 3'd2, 24'd6, 8'h40, 0, 2'b01, 1, 3'd2, "R2");
        // R3: preemption refused
        apply(1, 0, 1, 3'd3, 24'd7, 8'h40, 0, 2'b01, 0, 3'd2, "R3");
        // R8: no strobe with an otherwise grantable candidate
        apply(0, 0, 1, 3'd4, 24'd8, 8'h40, 0, 2'b01, 1, 3'd2, "R8");
        // R4 R6: last ordinary ID, top bit of group 1 (word 3, bit 31)
        apply(1, 1, 1, 3'd7, 24'd1019, 8'hFF, 1, 2'b01, 1, 3'd0, "R4");
        check(apr_g1[APR_W-1], "R6", "top bit g1", APR_W'(apr_g1[APR_W-1]), APR_W'(1));
        // R5: binary point 7 gives index 0 in group 0
        apply(1, 0, 1, 3'd0, 24'd30, 8'h80, 0, 2'b01, 1, 3'd7, "R5");
        check(apr_g0[0], "R5", "bit0 g0", APR_W'(apr_g0[0]), APR_W'(1));
        // R5: binary point 3, priority 0xB7 -> index 88
        apply(1, 0, 1, 3'd5, 24'd31, 8'hB7, 0, 2'b01, 1, 3'd3, "R5");
        check(apr_g0[88], "R5", "bit88 g0", APR_W'(apr_g0[88]), APR_W'(1));
        // R7: reserved IDs
        apply(1, 0, 1, 3'd6, 24'd1020, 8'h10, 0, 2'b11, 1, 3'd0, "R7");
        apply(1, 1, 1, 3'd2, 24'd1023, 8'h20, 1, 2'b01, 1, 3'd1, "R7");
        apply(1, 1, 1, 3'd1, 24'h123456, 8'h30, 1, 2'b01, 1, 3'd4, "R7");

        // Random mix over all requirements
        for (int n = 0; n < 600; n++) begin
            int sel;
            sel = $urandom_range(0, 9);
            rid = (sel == 0) ? 24'(1020 + $urandom_range(0, 3)) :
                  (sel == 1) ? 24'($urandom) : 24'($urandom_range(0, 1019));
            apply($urandom_range(0, 9) != 0, 1'($urandom), $urandom_range(0, 4) != 0,
                  LR_IDX_W'($urandom), rid, 8'($urandom), 1'($urandom), 2'($urandom),
                  $urandom_range(0, 4) != 0, 3'($urandom), "R4-random");
        end

        // R9: reset clears accumulated bits
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mdl_g0 = '0;
        mdl_g1 = '0;
        check(apr_g0 == '0 && apr_g1 == '0, "R9", "reclear arrays", apr_g0 | apr_g1, '0);
        apply(1, 0, 1, 3'd0, 24'd100, 8'h44, 0, 2'b01, 1, 3'd1, "R6");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule